// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier with Split High/Low Result

This block multiplies two W-bit operands (W defaults to 32) over several clock cycles using the schoolbook shift-and-add method. The multiplicand is widened to 2W bits and moves one place toward the most significant end per step. The multiplier moves one place toward the least significant end per step. Whenever the multiplier's bit 0 is set, a 2W-bit adder accumulates the multiplicand into a product register. When the operation completes, the upper W bits of the product are loaded into the `hi_o` register and the lower W bits into the `lo_o` register.

The caller presents the operands and the `signed_i` mode bit, then raises `start_i` for one cycle while `busy_o` is low. For a signed request, both operands are first replaced by their magnitudes and the XOR of the two sign bits is recorded. If that XOR is 1, the 2W-bit magnitude product is negated before the result registers are loaded.

The controller has three states:
- `ST_IDLE` waits for a start.
- `ST_CALC` performs one add/shift step per clock for W clocks.
- `ST_FINISH` loads the result registers and raises the completion pulse.

The transitions are:
- IDLE→CALC on an accepted start.
- CALC→CALC while steps remain.
- CALC→FINISH after step W.
- FINISH→IDLE unconditionally.

Top module: `seq_mul`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `hi_o` and `lo_o` are all zeros.
- R2: A `start_i` sampled high while `busy_o` is low captures `opa_i`, `opb_i` and `signed_i`. `busy_o` is high from the next cycle on.
- R3: `done_o` goes high exactly W+1 clock edges after the edge that accepted the start, whatever the operand values are.
- R4: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R5: With `signed_i`=0, the concatenation {`hi_o`,`lo_o`} equals the unsigned 2W-bit product of the two operands.
- R6: With `signed_i`=1, the operands are two's-complement values (bit W-1 is the sign). {`hi_o`,`lo_o`} equals their 2W-bit two's-complement product, including when an operand is the most negative value.
- R7: `hi_o` holds bits 2W-1..W of the product and `lo_o` holds bits W-1..0.
- R8: A `start_i` raised while `busy_o` is high is ignored. Operand or mode changes at that time do not alter the running result or its timing.
- R9: `hi_o` and `lo_o` change only in the cycle in which `done_o` is high. At all other times they keep their previous values, even when the operand inputs change.
- R10: A zero multiplier operand still takes the full W+1 cycles and yields `hi_o` and `lo_o` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new multiply (accepted only when idle) |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| opa_i | input | W | Multiplicand operand |
| opb_i | input | W | Multiplier operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: result registers just loaded |
| hi_o | output | W | Upper half of the last product |
| lo_o | output | W | Lower half of the last product |

## Verification
The bench sweeps every operand pair of a 6-bit configuration in both modes. This covers:
- The most negative value times itself and times -1. A design that took the magnitude or the final negation in too few bits would produce a wrong upper half here.
- Mixed-sign pairs. A sign XOR that was latched late, or taken from the live inputs, would give the wrong sign on these pairs.
- Zero multipliers. A design that stopped early on an exhausted multiplier would show a shortened latency on these.

A start pulse with different operands and mode is also injected mid-run. A controller that re-armed on it would corrupt the result or stretch the latency. The result registers are also watched across idle cycles while the inputs change, to catch a design that writes them at the wrong time.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
    parameter int W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_o
);
    logic a_neg, b_neg;

    always_comb begin
        a_neg   = signed_i & opa_i[W-1];
        b_neg   = signed_i & opb_i[W-1];
        // magnitude of the most negative value is 2^(W-1), still fits unsigned W bits
        mag_a_o = a_neg ? (~opa_i + 1'b1) : opa_i;
        mag_b_o = b_neg ? (~opb_i + 1'b1) : opb_i;
        neg_o   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_fsm.sv
module mul_fsm
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o
);
    localparam int CW = $clog2(W + 1);

    mul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic last_step;

    assign last_step = (cnt_q == CW'(W - 1));

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                cnt_q <= '0;
            else if (state_q == ST_CALC)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CALC;
            ST_CALC:   if (last_step) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_CALC:   step_o   = 1'b1;
            ST_FINISH: finish_o = 1'b1;
            default:   busy_o   = 1'b0;
        endcase
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_calc_no_shortcut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |=> (state_q != ST_IDLE));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |-> !load_o);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         finish_i,
    input  logic [W-1:0] mag_a_i,
    input  logic [W-1:0] mag_b_i,
    input  logic         neg_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o,
    output logic         done_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] prod_q;
    logic          neg_q;
    logic [PW-1:0] result;

    always_comb result = neg_q ? (~prod_q + 1'b1) : prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
            neg_q    <= 1'b0;
            hi_o     <= '0;
            lo_o     <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (load_i) begin
                mcand_q  <= {{W{1'b0}}, mag_a_i};
                mplier_q <= mag_b_i;
                prod_q   <= '0;
                neg_q    <= neg_i;
            end else if (step_i) begin
                if (mplier_q[0])
                    prod_q <= prod_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
            end
            if (finish_i) begin
                hi_o <= result[PW-1:W];
                lo_o <= result[W-1:0];
            end
        end
    end

    // every multiplier bit has been consumed by the time the result is loaded
    p_all_bits_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |-> (mplier_q == '0));
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W-1:0] mag_a, mag_b;
    logic         neg;
    logic         load, step, finish;

    mul_operand_prep #(.W(W)) u_prep (
        .signed_i (signed_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .neg_o    (neg)
    );

    mul_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .finish_i (finish),
        .mag_a_i  (mag_a),
        .mag_b_i  (mag_b),
        .neg_i    (neg),
        .hi_o     (hi_o),
        .lo_o     (lo_o),
        .done_o   (done_o)
    );

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

// File: tb/sim_seq_mul.sv
module sim_seq_mul;
    localparam int  W      = 6;
    localparam int  PW     = 2 * W;
    localparam time CLK_P  = 10ns;
    localparam int  WD_MAX = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    seq_mul #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one multiply; disturb=1 injects a start with different operands mid-run (R8)
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit sgn, input bit disturb);
        logic [PW-1:0] ea, eb, ep;
        logic [PW-1:0] got;
        int n;
        ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        ep = ea * eb;
        @(negedge clk);
        opa_i = a; opb_i = b; signed_i = sgn; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
        n = 0;
        if (disturb) begin
            @(negedge clk); n++;
            opa_i = ~a; opb_i = b + 1'b1; signed_i = ~sgn; start_i = 1'b1;
            @(negedge clk); n++;
            @(negedge clk); n++;
            start_i = 1'b0;
        end
        while (!done_o && n < 4 * W) begin
            @(negedge clk);
            n++;
        end
        got = {hi_o, lo_o};
        chk(n == W + 1, disturb ? "R8 latency with busy start" :
            (b == '0 ? "R10 latency zero multiplier" : "R3 latency"),
            64'(n), 64'(W + 1));
        if (disturb)
            chk(got == ep, "R8 result with busy start", 64'(got), 64'(ep));
        else if (b == '0)
            chk(got == '0, "R10 zero multiplier result", 64'(got), 64'd0);
        else if (sgn)
            chk(got == ep, "R6 R7 signed product", 64'(got), 64'(ep));
        else
            chk(got == ep, "R5 R7 unsigned product", 64'(got), 64'(ep));
        chk(busy_o == 1'b0, "R4 idle while done", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R4 done one cycle", 64'(done_o), 64'd0);
        chk({hi_o, lo_o} == ep, "R9 result held", 64'({hi_o, lo_o}), 64'(ep));
    endtask

    initial begin
        while (cycles < WD_MAX) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 2.3);
        chk({busy_o, done_o, hi_o, lo_o} == '0, "R1 state during reset",
            64'({busy_o, done_o, hi_o, lo_o}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, hi_o, lo_o} == '0, "R1 state after reset",
            64'({busy_o, done_o, hi_o, lo_o}), 64'd0);

        // corner cases first: most negative value, -1, zero
        run_op(6'b100000, 6'b100000, 1'b1, 1'b0);
        run_op(6'b100000, 6'b111111, 1'b1, 1'b0);
        run_op(6'b111111, 6'b111111, 1'b0, 1'b0);
        run_op(6'b010101, 6'b000000, 1'b1, 1'b0);

        // R8: start while busy is ignored
        run_op(6'd5, 6'd7, 1'b0, 1'b1);
        run_op(6'b111011, 6'd3, 1'b1, 1'b1);

        // R9: inputs wander while idle, result registers must not move
        opa_i = 6'd9; opb_i = 6'd11; signed_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            opa_i = opa_i + 6'd13;
            chk({hi_o, lo_o} == 12'b111111_110001, "R9 idle hold",
                64'({hi_o, lo_o}), 64'hFF1);
        end

        // exhaustive sweep, both modes
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    run_op(W'(a), W'(b), s[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule